// File: doc/BRIEF.md
# Multi-Depth Pixel Unpacker

This block takes 32-bit words read from a frame buffer and splits each one into display pixels. A three-bit depth code selects the pixel depth. At 8 bits per pixel and below, each pixel is a palette index that a downstream lookup resolves. At 16 and 32 bits the colour value is passed through directly, and the red and blue fields can optionally be exchanged. Two ordering flags choose how pixels are laid out inside a word. The byte-reversal flag outranks the pixel-reversal flag, and with neither flag set the layout is little-endian.

Words arrive on a valid/ready stream. Pixels leave one per cycle, each with a flag that tells an index from a direct colour and a marker on the last pixel of every line. The block also reports how many bytes one line of the frame buffer occupies for the current depth and column count. No word is taken and no pixel is produced unless both the enable input and the power input are high.

Top module: `pix_unpacker`

## Requirements
- R1: Depth codes 0, 1, 2, 3, 4 and 5 select 1, 2, 4, 8, 16 and 32 bits per pixel. Codes 6 and 7 behave exactly like code 5. One word yields 32 divided by the pixel depth pixels.
- R2: `lineBytes` equals `columns` shifted right by 3, 2 or 1 for codes 0, 1 and 2. It equals `columns` for code 3. It equals `columns` times 2 for code 4 and `columns` times 4 for codes 5 to 7.
- R3: With both ordering flags low, pixel k of a word (k counted from 0) is taken from word bits [k*d +: d], where d is the pixel depth.
- R4: With only `pixRevOrder` high and d below 8, the pixels inside each byte are taken from the most significant end first, while the bytes are still visited from byte 0 upward. For d of 8 or more this flag has no effect.
- R5: With `byteRevOrder` high, the four bytes of the word are first reversed (byte 3 becomes byte 0). The pixel-reversed rule of R4 is then applied to that reversed word, whatever the value of `pixRevOrder`.
- R6: With `swapRedBlue` high, a 16-bit pixel has bits [15:11] and [4:0] exchanged, and a 32-bit pixel has bits [23:16] and [7:0] exchanged. Palette indices are never altered by this flag.
- R7: While `dispEnable` or `dispPower` is low, `wordReady` and `pixValid` stay low and no word is consumed.
- R8: `pixIsIndex` is 1 on every pixel produced at codes 0 to 3 and 0 at codes 4 to 7. Index pixels are zero above their d bits in the 32-bit `pixData`.
- R9: `pixEol` is high together with the pixel that completes a line of `columns` pixels. The following pixel starts a new line.
- R10: A word accepted while the block is idle produces its first pixel in the next cycle. Its remaining pixels follow on consecutive cycles. A new word can be accepted in the cycle that carries the last pixel of the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispEnable | input | 1 | Display enable |
| dispPower | input | 1 | Display power |
| depthCode | input | 3 | Pixel depth code |
| byteRevOrder | input | 1 | Byte-reversed word order (wins over pixRevOrder) |
| pixRevOrder | input | 1 | Pixel-reversed order within each byte |
| swapRedBlue | input | 1 | Exchange red and blue fields of direct colour |
| columns | input | COL_W | Pixels per line |
| lineBytes | output | COL_W+2 | Bytes per frame-buffer line |
| wordValid | input | 1 | Input word valid |
| wordData | input | 32 | Input word |
| wordReady | output | 1 | Input word accepted when high with wordValid |
| pixValid | output | 1 | Output pixel valid |
| pixData | output | 32 | Pixel index or direct colour |
| pixIsIndex | output | 1 | 1 for a palette index, 0 for direct colour |
| pixEol | output | 1 | Last pixel of a line |

## Verification
Words with distinct bit patterns are pushed at every depth code. Each code is run in little-endian layout, with pixel reversal, with byte reversal, and with both flags set, so a wrong slot offset or a wrong flag priority gives a different pixel. Asymmetric colour words are sent with and without the red/blue exchange at 16 bits, at 32 bits and at an index depth, which separates field placement from index pass-through. Line lengths that end mid-stream check the end-of-line marker. Gating with the power input low checks that nothing is consumed until both control inputs are high.

// File: rtl/pix_unpacker_pkg.sv
package pix_unpacker_pkg;

  localparam int WORD_W = 32;
  localparam int SLOT_W = $clog2(WORD_W);

  typedef struct packed {
    logic              loadWord;
    logic              stepPix;
    logic [SLOT_W-1:0] slot;
  } strobe_t;

  function automatic logic [2:0] depthLog(input logic [2:0] code);
    return (code > 3'd5) ? 3'd5 : code;
  endfunction

endpackage

// File: rtl/pix_unpacker_ctrl.sv
module pix_unpacker_ctrl
  import pix_unpacker_pkg::*;
#(
  parameter int COL_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enabled,
  input  logic [2:0]       depthCode,
  input  logic [COL_W-1:0] columns,
  input  logic             wordValid,
  output logic             wordReady,
  output logic             pixEol,
  output strobe_t          strobe
);

  logic              busy;
  logic [SLOT_W-1:0] slot;
  logic [COL_W-1:0]  colCount;
  logic [SLOT_W:0]   pixPerWord;
  logic              lastSlot;
  logic              stepPix;
  logic              loadWord;

  always_comb begin
    pixPerWord = (SLOT_W+1)'(WORD_W) >> depthLog(depthCode);
    lastSlot   = ({1'b0, slot} >= pixPerWord - 1'b1);
    stepPix    = enabled && busy;
    wordReady  = enabled && (!busy || lastSlot);
    loadWord   = wordValid && wordReady;
    pixEol     = stepPix && ((COL_W+1)'(colCount) + 1'b1 >= (COL_W+1)'(columns));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (loadWord) begin
      busy <= 1'b1;
      slot <= '0;
    end else if (stepPix && lastSlot) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (stepPix) begin
      slot <= slot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCount <= '0;
    end else if (stepPix) begin
      colCount <= pixEol ? '0 : colCount + 1'b1;
    end
  end

  assign strobe.loadWord = loadWord;
  assign strobe.stepPix  = stepPix;
  assign strobe.slot     = slot;

endmodule

// File: rtl/pix_unpacker_dp.sv
module pix_unpacker_dp
  import pix_unpacker_pkg::*;
#(
  parameter int COL_W = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [2:0]         depthCode,
  input  logic               byteRevOrder,
  input  logic               pixRevOrder,
  input  logic               swapRedBlue,
  input  logic [COL_W-1:0]   columns,
  input  logic [WORD_W-1:0]  wordData,
  output logic [WORD_W-1:0]  pixData,
  output logic               pixIsIndex,
  output logic [COL_W+1:0]   lineBytes
);

  localparam int LB_W = COL_W + 5;

  logic [WORD_W-1:0] wordQ;
  logic [WORD_W-1:0] wordSel;
  logic [2:0]        depLog;
  logic [5:0]        bpp;
  logic [5:0]        pos;
  logic [5:0]        offset;
  logic              reverse;
  logic [WORD_W:0]   maskWide;
  logic [WORD_W-1:0] raw;
  logic [LB_W-1:0]   lbWide;

  always_ff @(posedge clk) begin
    if (!rstN)               wordQ <= '0;
    else if (strobe.loadWord) wordQ <= wordData;
  end

  always_comb begin
    depLog  = depthLog(depthCode);
    bpp     = 6'd1 << depLog;
    reverse = byteRevOrder || pixRevOrder;
    pos     = 6'(strobe.slot) << depLog;
    for (int b = 0; b < WORD_W / 8; b++) begin
      wordSel[8*b +: 8] = byteRevOrder ? wordQ[8*(WORD_W/8-1-b) +: 8] : wordQ[8*b +: 8];
    end
    if (reverse && depLog < 3'd3)
      offset = {pos[5:3], 3'b000} + (6'd8 - bpp - {3'b000, pos[2:0]});
    else
      offset = pos;
    maskWide = ((WORD_W+1)'(1) << bpp) - 1'b1;
    raw      = (wordSel >> offset) & maskWide[WORD_W-1:0];
    pixIsIndex = (depLog <= 3'd3);
    if (swapRedBlue && depLog == 3'd4)
      pixData = {raw[31:16], raw[4:0], raw[10:5], raw[15:11]};
    else if (swapRedBlue && depLog == 3'd5)
      pixData = {raw[31:24], raw[7:0], raw[15:8], raw[23:16]};
    else
      pixData = raw;
    lbWide    = (LB_W'(columns) << depLog) >> 3;
    lineBytes = lbWide[COL_W+1:0];
  end

endmodule

// File: rtl/pix_unpacker.sv
module pix_unpacker
  import pix_unpacker_pkg::*;
#(
  parameter int COL_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispEnable,
  input  logic             dispPower,
  input  logic [2:0]       depthCode,
  input  logic             byteRevOrder,
  input  logic             pixRevOrder,
  input  logic             swapRedBlue,
  input  logic [COL_W-1:0] columns,
  output logic [COL_W+1:0] lineBytes,
  input  logic             wordValid,
  input  logic [31:0]      wordData,
  output logic             wordReady,
  output logic             pixValid,
  output logic [31:0]      pixData,
  output logic             pixIsIndex,
  output logic             pixEol
);

  strobe_t strobe;
  logic    enabled;

  assign enabled  = dispEnable && dispPower;
  assign pixValid = strobe.stepPix;

  pix_unpacker_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enabled   (enabled),
    .depthCode (depthCode),
    .columns   (columns),
    .wordValid (wordValid),
    .wordReady (wordReady),
    .pixEol    (pixEol),
    .strobe    (strobe)
  );

  pix_unpacker_dp #(.COL_W(COL_W)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .depthCode    (depthCode),
    .byteRevOrder (byteRevOrder),
    .pixRevOrder  (pixRevOrder),
    .swapRedBlue  (swapRedBlue),
    .columns      (columns),
    .wordData     (wordData),
    .pixData      (pixData),
    .pixIsIndex   (pixIsIndex),
    .lineBytes    (lineBytes)
  );

endmodule

// File: rtl/pix_unpacker_chk.sv
module pix_unpacker_chk #(
  parameter int COL_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             dispEnable,
  input logic             dispPower,
  input logic [2:0]       depthCode,
  input logic [COL_W-1:0] columns,
  input logic [COL_W+1:0] lineBytes,
  input logic             wordValid,
  input logic             wordReady,
  input logic             pixValid,
  input logic [31:0]      pixData,
  input logic             pixIsIndex,
  input logic             pixEol
);

  assert_gate_pix_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(dispEnable && dispPower) |-> !pixValid);

  assert_gate_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> (dispEnable && dispPower));

  assert_eol_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    pixEol |-> pixValid);

  assert_one_bit_index_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && depthCode == 3'd0) |-> (pixIsIndex && pixData[31:1] == 31'd0));

  assert_start_next_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordReady) |=> (!(dispEnable && dispPower) || pixValid));

  assert_byte_line_R2: assert property (@(posedge clk) disable iff (!rstN)
    (depthCode == 3'd3) |-> (lineBytes == (COL_W+2)'(columns)));

endmodule

bind pix_unpacker pix_unpacker_chk #(.COL_W(COL_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dispEnable (dispEnable),
  .dispPower  (dispPower),
  .depthCode  (depthCode),
  .columns    (columns),
  .lineBytes  (lineBytes),
  .wordValid  (wordValid),
  .wordReady  (wordReady),
  .pixValid   (pixValid),
  .pixData    (pixData),
  .pixIsIndex (pixIsIndex),
  .pixEol     (pixEol)
);

// File: tb/test_pix_unpacker.sv
module test_pix_unpacker;

  localparam int COL_W = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             dispEnable = 1'b0;
  logic             dispPower = 1'b0;
  logic [2:0]       depthCode = 3'd0;
  logic             byteRevOrder = 1'b0;
  logic             pixRevOrder = 1'b0;
  logic             swapRedBlue = 1'b0;
  logic [COL_W-1:0] columns = 12'd32;
  logic [COL_W+1:0] lineBytes;
  logic             wordValid = 1'b0;
  logic [31:0]      wordData = '0;
  logic             wordReady;
  logic             pixValid;
  logic [31:0]      pixData;
  logic             pixIsIndex;
  logic             pixEol;

  int errors = 0;
  int checks = 0;
  int pixCnt = 0;
  string curTag = "R3";

  logic [31:0] expData[$];
  logic        expIdx[$];
  logic        expEol[$];
  string       expTag[$];

  always #10 clk = ~clk;

  pix_unpacker #(.COL_W(COL_W)) i_pix_unpacker (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] w, input int k);
    int lg, bpp, base, lo;
    logic [31:0] v, r;
    lg  = (depthCode > 3'd5) ? 5 : int'(depthCode);
    bpp = 1 << lg;
    v   = w;
    if (byteRevOrder) for (int i = 0; i < 4; i++) v[8*i +: 8] = w[8*(3-i) +: 8];
    base = k * bpp;
    if ((byteRevOrder || pixRevOrder) && bpp < 8) lo = (base / 8) * 8 + (8 - bpp - base % 8);
    else lo = base;
    r = '0;
    for (int b = 0; b < bpp; b++) r[b] = v[lo + b];
    if (swapRedBlue && lg == 4) r = {r[31:16], r[4:0], r[10:5], r[15:11]};
    if (swapRedBlue && lg == 5) r = {r[31:24], r[7:0], r[15:8], r[23:16]};
    return r;
  endfunction

  task automatic sendWord(input logic [31:0] w);
    int lg;
    lg = (depthCode > 3'd5) ? 5 : int'(depthCode);
    for (int k = 0; k < (32 >> lg); k++) begin
      expData.push_back(model(w, k));
      expIdx.push_back(lg <= 3);
      pixCnt++;
      expEol.push_back(pixCnt == int'(columns));
      if (pixCnt == int'(columns)) pixCnt = 0;
      expTag.push_back(curTag);
    end
    wordValid = 1'b1;
    wordData  = w;
    #1;
    while (!wordReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic drain();
    while (expData.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rstN && pixValid) begin
      if (expData.size() == 0) begin
        check("R7 unexpected pixel", 64'(pixData), 64'hDEAD);
      end else begin
        automatic string t = expTag.pop_front();
        check(t, 64'(pixData), 64'(expData.pop_front()));
        check("R8", 64'(pixIsIndex), 64'(expIdx.pop_front()));
        check("R9", 64'(pixEol), 64'(expEol.pop_front()));
      end
    end
  end

  task automatic setMode(input int code, input logic bb, input logic pb, input logic sw,
                         input int cols, input string tag);
    depthCode = 3'(code); byteRevOrder = bb; pixRevOrder = pb; swapRedBlue = sw;
    columns = COL_W'(cols); curTag = tag; pixCnt = 0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 reset pixValid", 64'(pixValid), 0);
    check("R7 reset wordReady", 64'(wordReady), 0);

    columns = 12'd100;
    for (int c = 0; c < 8; c++) begin
      int lg;
      lg = (c > 5) ? 5 : c;
      depthCode = 3'(c);
      #1;
      check("R2 lineBytes", 64'(lineBytes), 64'((100 << lg) >> 3));
    end

    // R7: power low holds the word
    dispEnable = 1'b1;
    setMode(3, 0, 0, 0, 4, "R7");
    wordValid = 1'b1; wordData = 32'h44332211;
    repeat (4) begin
      @(negedge clk);
      check("R7 gated ready", 64'(wordReady), 0);
      check("R7 gated valid", 64'(pixValid), 0);
    end
    wordValid = 1'b0;
    dispPower = 1'b1;
    sendWord(32'h44332211);
    drain();

    // R10 timing: four pixels on consecutive cycles after accept
    setMode(3, 0, 0, 0, 4, "R10");
    sendWord(32'hA1B2C3D4);
    for (int i = 0; i < 4; i++) begin
      check("R10 consecutive", 64'(pixValid), 1);
      @(negedge clk);
    end
    check("R10 idle after word", 64'(pixValid), 0);
    drain();

    // R1/R3 all depths little-endian
    for (int c = 0; c < 8; c++) begin
      int lg;
      lg = (c > 5) ? 5 : c;
      setMode(c, 0, 0, 0, 2 * (32 >> lg), c > 5 ? "R1" : "R3");
      sendWord(32'h8F3C_5A17);
      sendWord(32'h0123_4567);
      drain();
    end

    // R4 pixel reversal, R5 byte reversal and precedence
    for (int c = 0; c < 6; c++) begin
      setMode(c, 0, 1, 0, 32 >> c, "R4");
      sendWord(32'hC6A5_1E93);
      drain();
      setMode(c, 1, 0, 0, 32 >> c, "R5");
      sendWord(32'hC6A5_1E93);
      drain();
      setMode(c, 1, 1, 0, 32 >> c, "R5");
      sendWord(32'hC6A5_1E93);
      drain();
    end

    // R6 red/blue exchange
    setMode(4, 0, 0, 1, 4, "R6");
    sendWord(32'hF81F_07E0); sendWord(32'h1234_ABCD);
    drain();
    setMode(5, 0, 0, 1, 2, "R6");
    sendWord(32'h00FF_0011); sendWord(32'h7A5B_3C2D);
    drain();
    setMode(3, 0, 0, 1, 4, "R6");
    sendWord(32'hF0E1_D2C3);
    drain();

    // R9 line ending mid-word, back-to-back words
    setMode(2, 0, 0, 0, 6, "R9");
    sendWord(32'h7654_3210); sendWord(32'hFEDC_BA98); sendWord(32'h1357_9BDF);
    drain();

    check("R10 queue empty", 64'(expData.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule